// File: doc/BRIEF.md
# Asynchronous Static RAM Interface Controller

This block lets an on-chip requester read and write a 32K x 8 asynchronous static RAM through a clocked request/ready handshake. A request carries an address, a direction and, for writes, one data byte. The controller holds the address steady and steps the active-low chip-enable, write-enable and output-enable strobes through a fixed sequence. It returns read data with a one-clock valid strobe.

Every minimum interval of the memory is a parameter counted in clock cycles: the read access time, the write pulse width, the address-valid-to-write-end time, the write cycle time and the bus release time. The write setup and recovery phases are derived from these parameters. The data bus is split into an output value, an input value and an output enable. The enable is high only while the write strobe is low. After every read, the controller waits out the memory's bus release time before it accepts another request.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, chip enable, write enable and output enable are high, the data-bus enable is low, ready is high and read-valid is low.
- R2: A request is taken only in a cycle where ready is high. Ready is low from the cycle after acceptance until the access ends, and requests presented while it is low change neither the memory contents nor the timing of the access in progress.
- R3: A read holds chip enable and output enable low, with write enable high, for exactly RD_ACCESS_CYC cycles, and returns the byte stored at the requested address.
- R4: Read-valid is high for exactly one cycle, RD_ACCESS_CYC cycles after the acceptance edge, and read data is the bus value sampled while output enable is still low. Writes produce no read-valid.
- R5: A write holds write enable low for exactly WR_PULSE_CYC cycles. Chip enable is low with write enable high for SETUP = max(1, ADDR_VALID_CYC - WR_PULSE_CYC) cycles before the strobe falls.
- R6: The data-bus enable is high only while chip enable and write enable are low and output enable is high.
- R7: After a read, ready returns RD_ACCESS_CYC + 1 + TURN_CYC cycles after the acceptance edge, and all strobes are high in between.
- R8: After a write, ready returns SETUP + WR_PULSE_CYC + RECOVER cycles after the acceptance edge, where RECOVER = max(1, WR_CYCLE_CYC - SETUP - WR_PULSE_CYC).
- R9: The memory address does not change during any cycle in which chip enable stays low.
- R10: Output enable and write enable are never low together, and neither is low while chip enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| req_ready | output | 1 | Controller idle; a request is taken at the next edge |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | DATA_W | Read byte |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_out | output | DATA_W | Data driven to the memory |
| mem_dq_in | input | DATA_W | Data received from the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |

## Verification
Every strobe is registered straight from the sequencer state. A wrong state therefore appears on the pins at the next edge. It shows as a strobe combination the memory model rejects, a bus drive with output enable low, or a write pulse of the wrong length, all flagged in that cycle. A phase-timer miscount shifts the cycle in which ready or read-valid appears, and each access checks that cycle. A capture taken too early returns the model's deliberately wrong pre-access data. An accepted stray request during a busy period corrupts a location that is read back later.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_DONE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER,
        ST_TURNAROUND
    } seq_state_e;

    // Pin-level control bundle, active-low strobes plus bus drive enable
    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic drive;
    } pin_ctl_t;

    localparam pin_ctl_t PINS_QUIET = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Strobe pattern belonging to each sequencer state
    function automatic pin_ctl_t pins_for(input seq_state_e s);
        pin_ctl_t p;
        p = PINS_QUIET;
        case (s)
            ST_RD_ACCESS: begin
                p.ce_n = 1'b0;
                p.oe_n = 1'b0;
            end
            ST_WR_SETUP, ST_WR_RECOVER: begin
                p.ce_n = 1'b0;
            end
            ST_WR_PULSE: begin
                p.ce_n  = 1'b0;
                p.we_n  = 1'b0;
                p.drive = 1'b1;
            end
            default: p = PINS_QUIET;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    assign last = run && (cnt_q == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run || last) cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q < limit)); // R3

endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int RD_CYC    = 7,
    parameter int TURN_CYC  = 3,
    parameter int SETUP_CYC = 1,
    parameter int WP_CYC    = 4,
    parameter int REC_CYC   = 2,
    parameter int CNT_W     = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     req_valid,
    input  logic     req_write,
    output logic     accept,
    output logic     ready,
    output logic     capture,
    output pin_ctl_t pins
);
    seq_state_e       state_q, state_nx;
    pin_ctl_t         pins_q;
    logic             ready_q;
    logic             tm_run, tm_last;
    logic [CNT_W-1:0] tm_limit;

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign tm_run  = (state_q != ST_IDLE);
    assign capture = (state_q == ST_RD_ACCESS) && tm_last;

    always_comb begin
        case (state_q)
            ST_RD_ACCESS:  tm_limit = CNT_W'(RD_CYC);
            ST_TURNAROUND: tm_limit = CNT_W'(TURN_CYC);
            ST_WR_SETUP:   tm_limit = CNT_W'(SETUP_CYC);
            ST_WR_PULSE:   tm_limit = CNT_W'(WP_CYC);
            ST_WR_RECOVER: tm_limit = CNT_W'(REC_CYC);
            default:       tm_limit = CNT_W'(1);
        endcase
    end

    sram_phase_timer #(.CNT_W(CNT_W)) i_timer (
        .clk   (clk),
        .rst   (rst),
        .run   (tm_run),
        .limit (tm_limit),
        .last  (tm_last)
    );

    always_comb begin
        state_nx = state_q;
        case (state_q)
            ST_IDLE:       if (req_valid) state_nx = req_write ? ST_WR_SETUP : ST_RD_ACCESS;
            ST_RD_ACCESS:  if (tm_last) state_nx = ST_RD_DONE;
            ST_RD_DONE:    state_nx = ST_TURNAROUND;
            ST_TURNAROUND: if (tm_last) state_nx = ST_IDLE;
            ST_WR_SETUP:   if (tm_last) state_nx = ST_WR_PULSE;
            ST_WR_PULSE:   if (tm_last) state_nx = ST_WR_RECOVER;
            ST_WR_RECOVER: if (tm_last) state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // Strobes registered from the next state: glitch-free pins aligned to the state
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pins_q  <= PINS_QUIET;
            ready_q <= 1'b1;
        end else begin
            state_q <= state_nx;
            pins_q  <= pins_for(state_nx);
            ready_q <= (state_nx == ST_IDLE);
        end
    end

    assign pins  = pins_q;
    assign ready = ready_q;

    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (rst)
        pins_q.drive |-> (pins_q.oe_n && !pins_q.we_n && !pins_q.ce_n)); // R6
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!pins_q.oe_n && !pins_q.we_n)); // R10
    AST_CE_GATES: assert property (@(posedge clk) disable iff (rst)
        pins_q.ce_n |-> (pins_q.we_n && pins_q.oe_n)); // R10
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
        ready_q |-> (pins_q.ce_n && !pins_q.drive)); // R2
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        accept |=> !ready_q); // R2
    AST_CAPTURE_OE: assert property (@(posedge clk) disable iff (rst)
        capture |-> (!pins_q.oe_n && !pins_q.ce_n && pins_q.we_n)); // R4

endmodule

// File: rtl/sram_data_path.sv
`timescale 1ns/1ps
module sram_data_path #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic              ce_n,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              rvalid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) rdata_q <= dq_in;
            rvalid_q <= capture;
        end
    end

    assign mem_addr = addr_q;
    assign dq_out   = wdata_q;
    assign rd_data  = rdata_q;
    assign rd_valid = rvalid_q;

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !$past(ce_n)) |-> (addr_q == $past(addr_q))); // R9
    AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        rvalid_q |=> !rvalid_q); // R4

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W         = 15,
    parameter int DATA_W         = 8,
    parameter int RD_ACCESS_CYC  = 7,
    parameter int WR_PULSE_CYC   = 4,
    parameter int ADDR_VALID_CYC = 5,
    parameter int WR_CYCLE_CYC   = 7,
    parameter int TURN_CYC       = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    localparam int SETUP_CYC = int'(max2(1, (ADDR_VALID_CYC > WR_PULSE_CYC) ?
                                            ADDR_VALID_CYC - WR_PULSE_CYC : 0));
    localparam int REC_CYC   = int'(max2(1, (WR_CYCLE_CYC > SETUP_CYC + WR_PULSE_CYC) ?
                                            WR_CYCLE_CYC - SETUP_CYC - WR_PULSE_CYC : 0));
    localparam int MAX_CYC   = int'(max2(max2(RD_ACCESS_CYC, TURN_CYC),
                                         max2(max2(SETUP_CYC, WR_PULSE_CYC), REC_CYC)));
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    logic     accept, capture;
    pin_ctl_t pins;

    sram_seq_fsm #(
        .RD_CYC    (RD_ACCESS_CYC),
        .TURN_CYC  (TURN_CYC),
        .SETUP_CYC (SETUP_CYC),
        .WP_CYC    (WR_PULSE_CYC),
        .REC_CYC   (REC_CYC),
        .CNT_W     (CNT_W)
    ) i_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .accept    (accept),
        .ready     (req_ready),
        .capture   (capture),
        .pins      (pins)
    );

    sram_data_path #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_dp (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .capture   (capture),
        .ce_n      (pins.ce_n),
        .dq_in     (mem_dq_in),
        .mem_addr  (mem_addr),
        .dq_out    (mem_dq_out),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    assign mem_ce_n  = pins.ce_n;
    assign mem_we_n  = pins.we_n;
    assign mem_oe_n  = pins.oe_n;
    assign mem_dq_oe = pins.drive;

endmodule

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;
    localparam int AW = 15, DW = 8, MW = 9;
    localparam int RD = 14, WP = 7, AV = 9, WC = 14, TURN = 6;
    localparam int SETUP = (AV - WP > 1) ? AV - WP : 1;
    localparam int REC   = (WC - SETUP - WP > 1) ? WC - SETUP - WP : 1;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rd_valid, ce_n, we_n, oe_n, dq_oe;
    logic [DW-1:0] rd_data, dq_out, dq_in;
    logic [AW-1:0] maddr;

    int nchk = 0, nfail = 0, mon_chk = 0, mon_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sram_async_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .RD_ACCESS_CYC(RD), .WR_PULSE_CYC(WP),
        .ADDR_VALID_CYC(AV), .WR_CYCLE_CYC(WC), .TURN_CYC(TURN)
    ) i_sram_async_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_ce_n(ce_n), .mem_we_n(we_n),
        .mem_oe_n(oe_n), .mem_addr(maddr), .mem_dq_out(dq_out), .mem_dq_in(dq_in),
        .mem_dq_oe(dq_oe)
    );

    function automatic logic [MW-1:0] fold(input logic [AW-1:0] a);
        return a[MW-1:0] ^ {3'b000, a[AW-1:MW]};
    endfunction
    function automatic logic [DW-1:0] init_val(input int i);
        return DW'(i * 29 + 3);
    endfunction

    // ---------------- behavioural memory model ----------------
    logic [DW-1:0] mdl_mem [0:(1<<MW)-1];
    logic [DW-1:0] exp_mem [0:(1<<MW)-1];
    int rd_cnt, wp_cnt, pre_cnt;
    logic rd_prev, wr_prev, ce_prev;
    logic [AW-1:0] addr_prev, waddr;
    logic [DW-1:0] wdat;
    logic rd_act, wr_act;

    assign rd_act = !ce_n && !oe_n && we_n;
    assign wr_act = !ce_n && !we_n;
    assign dq_in  = rd_act ? ((rd_cnt >= RD - 1) ? mdl_mem[fold(maddr)] : ~mdl_mem[fold(maddr)]) : '0;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < (1 << MW); i++) mdl_mem[i] <= init_val(i);
            rd_cnt <= 0; wp_cnt <= 0; pre_cnt <= 0;
            rd_prev <= 1'b0; wr_prev <= 1'b0; ce_prev <= 1'b1; addr_prev <= '0;
        end else begin
            if (rd_act) rd_cnt <= rd_cnt + 1;
            else if (rd_prev) begin
                mon_chk++;
                if (rd_cnt != RD) begin
                    mon_fail++;
                    $display("FAIL R3 read strobe cycles actual=%0d expected=%0d", rd_cnt, RD);
                end
                rd_cnt <= 0;
            end
            if (ce_n) pre_cnt <= 0;
            else if (we_n && oe_n) pre_cnt <= pre_cnt + 1;
            if (wr_act) begin
                if (!wr_prev) begin
                    mon_chk++;
                    if (pre_cnt != SETUP) begin
                        mon_fail++;
                        $display("FAIL R5 setup cycles actual=%0d expected=%0d", pre_cnt, SETUP);
                    end
                end
                wp_cnt <= wp_cnt + 1;
                wdat   <= dq_out;
                waddr  <= maddr;
                if (!dq_oe) begin
                    mon_fail++;
                    $display("FAIL R6 bus not driven in write actual=%0d expected=%0d", dq_oe, 1);
                end
            end else if (wr_prev) begin
                mon_chk++;
                if (wp_cnt != WP) begin
                    mon_fail++;
                    $display("FAIL R5 write pulse cycles actual=%0d expected=%0d", wp_cnt, WP);
                end
                mdl_mem[fold(waddr)] <= wdat;
                wp_cnt <= 0;
            end
            if (dq_oe && (!oe_n || we_n || ce_n)) begin
                mon_fail++;
                $display("FAIL R6 bus driven outside write actual=%b%b%b expected=010", ce_n, we_n, oe_n);
            end
            if ((!we_n && !oe_n) || (ce_n && (!we_n || !oe_n))) begin
                mon_fail++;
                $display("FAIL R10 strobe combination actual=%b%b%b expected=legal", ce_n, we_n, oe_n);
            end
            if (!ce_n && !ce_prev && maddr != addr_prev) begin
                mon_fail++;
                $display("FAIL R9 address moved actual=%0h expected=%0h", maddr, addr_prev);
            end
            rd_prev <= rd_act; wr_prev <= wr_act; ce_prev <= ce_n; addr_prev <= maddr;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit junk, input logic [AW-1:0] junk_addr);
        int c, vcnt, vat;
        logic [DW-1:0] got;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        c = 0; vcnt = 0; vat = -1; got = '0;
        forever begin
            if (rd_valid) begin
                vcnt++;
                if (vat < 0) vat = c;
                got = rd_data;
            end
            if (req_ready || c > 1000) break;
            if (junk) begin
                req_valid = 1'b1; req_write = 1'($urandom);
                req_addr = junk_addr; req_wdata = DW'($urandom);
            end
            @(negedge clk);
            c++;
        end
        req_valid = 1'b0;
        if (wr) begin
            exp_mem[fold(a)] = d;
            chk(c == SETUP + WP + REC, "R8", "write ready latency", c, SETUP + WP + REC);
            chk(vcnt == 0, "R4", "read-valid during write", vcnt, 0);
        end else begin
            chk(vat == RD, "R4", "read-valid cycle", vat, RD);
            chk(vcnt == 1, "R4", "read-valid width", vcnt, 1);
            chk(got == exp_mem[fold(a)], "R3", "read data", int'(got), int'(exp_mem[fold(a)]));
            chk(c == RD + 1 + TURN, "R7", "read ready latency", c, RD + 1 + TURN);
        end
    endtask

    task automatic chk_quiet(input string what);
        chk(ce_n && we_n && oe_n, "R1", {what, " strobes"}, {ce_n, we_n, oe_n}, 7);
        chk(!dq_oe, "R1", {what, " bus enable"}, dq_oe, 0);
        chk(req_ready, "R1", {what, " ready"}, req_ready, 1);
        chk(!rd_valid, "R1", {what, " read-valid"}, rd_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", nchk + mon_chk + 1, nfail + mon_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < (1 << MW); i++) exp_mem[i] = init_val(i);
        repeat (3) @(negedge clk);
        chk_quiet("in reset");
        rst = 1'b0;
        @(negedge clk);
        chk_quiet("after reset");

        // directed corner cases
        do_op(1'b0, 15'h0000, 8'h00, 1'b0, '0);       // R3 read of untouched location
        do_op(1'b1, 15'h7FFF, 8'hC3, 1'b0, '0);       // top address
        do_op(1'b0, 15'h7FFF, 8'h00, 1'b0, '0);
        do_op(1'b1, 15'h0001, 8'h00, 1'b0, '0);       // back-to-back writes
        do_op(1'b1, 15'h0001, 8'hFF, 1'b0, '0);
        do_op(1'b0, 15'h0001, 8'h00, 1'b0, '0);
        // R2: requests while busy must be ignored
        do_op(1'b1, 15'h1111, 8'h5A, 1'b1, 15'h2AAA);
        do_op(1'b0, 15'h2AAA, 8'h00, 1'b1, 15'h2AAA);
        chk(exp_mem[fold(15'h2AAA)] == init_val(int'(fold(15'h2AAA))), "R2",
            "stray request reference", 0, 0);
        do_op(1'b0, 15'h1111, 8'h00, 1'b0, '0);

        // constrained random traffic
        for (int n = 0; n < 300; n++) begin
            do_op(1'($urandom), AW'($urandom), DW'($urandom), ($urandom % 4) == 0, AW'($urandom));
        end
        // final read sweep of recently touched space
        for (int n = 0; n < 20; n++) do_op(1'b0, AW'(n * 1637), '0, 1'b0, '0);

        repeat (4) @(negedge clk);
        chk(ce_n && we_n && oe_n && !dq_oe, "R10", "quiet pins at end", {ce_n, we_n, oe_n, dq_oe}, 14);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk + mon_chk, nfail + mon_fail);
        $finish;
    end
endmodule